// File: doc/BRIEF.md
# TX packet framer with FIFO

This block accepts payload bytes from a host into a 64-byte transmit FIFO. On a start command it sends one framed packet on a single serial output, one bit for each bit-enable strobe. The frame is a preamble, a sync word, zero to four header bytes, the payload drawn from the FIFO, and an optional 16-bit CRC. Each byte goes out most significant bit first. The field lengths, the sync and header contents, the payload length and the CRC enable all come from configuration inputs. These inputs are read live, so the host holds them steady while a packet is in flight.

When the last byte of the frame has been sent, the framer goes back to idle by itself and raises a packet-sent event. It stays idle until the host issues a new start command, even if the FIFO still holds data. Three latched event bits are kept: packet sent, payload underflow and FIFO overflow. Each has its own enable toward an active-low interrupt output, and a read strobe clears all of them. Almost-full and almost-empty flags compare the FIFO fill level against two programmable 6-bit thresholds.

Top module: `pkt_tx_framer`

## Requirements
- R1: The preamble is `cfg_pre_m1`+1 bytes long (1 to 512), each byte 0x55, so the bits alternate and the first bit sent is 0.
- R2: The sync field is `cfg_sync_m1`+1 bytes (1 to 4), taken from `cfg_sync_word` starting at bits 31:24 and moving toward bit 0.
- R3: Fields go out in this order: preamble, sync, `cfg_hdr_len` header bytes (0 to 4, taken from `cfg_hdr` starting at bits 31:24), then `cfg_pay_len` payload bytes in FIFO write order. Every byte is sent MSB first, one bit per `bit_en` strobe, and each bit appears on `tx_bit` in the cycle after its strobe.
- R4: When `cfg_crc_en` is 1, the frame ends with two CRC bytes, high byte first. The CRC uses polynomial 0x1021 with seed 0xFFFF and covers the header and payload bytes only. When `cfg_crc_en` is 0, no CRC bytes are sent.
- R5: `tx_busy` rises in the cycle after `tx_start` is seen while idle. It falls on the strobe that sends the last bit, and status bit 0 (packet sent) is set at the same time. A `tx_start` while busy is ignored. Strobes while idle send nothing and take nothing from the FIFO.
- R6: If the FIFO is empty when a payload byte is due, 0x00 is sent in its place and status bit 1 (underflow) is set.
- R7: The FIFO holds 64 bytes, and `fifo_level` reports the fill count. A write while the level is 64 is dropped and sets status bit 2 (overflow).
- R8: A `fifo_clr` pulse empties the FIFO: the level becomes 0 and the old contents are discarded.
- R9: `fifo_afull` is 1 when the level is greater than the almost-full threshold. `fifo_aempty` is 1 when the level is less than or equal to the almost-empty threshold. After reset the thresholds are 55 and 4, and a `thr_wr` pulse loads both.
- R10: `irq_n` is 0 exactly when some status bit is set and its `irq_en` bit is 1. A disabled source still sets its status bit.
- R11: An `irq_rd` pulse clears every status bit, except a bit whose event occurs in that same cycle, which stays set.
- R12: After reset `tx_busy`, `tx_bit`, `fifo_level` and `irq_status` are 0, and `irq_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_wr | input | 1 | Write strobe for one payload byte |
| fifo_wdata | input | 8 | Byte to write |
| fifo_clr | input | 1 | Empties the FIFO |
| thr_wr | input | 1 | Loads both FIFO thresholds |
| thr_afull | input | 6 | Almost-full threshold to load |
| thr_aempty | input | 6 | Almost-empty threshold to load |
| fifo_level | output | 7 | FIFO fill count, 0 to 64 |
| fifo_afull | output | 1 | Level above the almost-full threshold |
| fifo_aempty | output | 1 | Level at or below the almost-empty threshold |
| tx_start | input | 1 | Starts one packet when idle |
| bit_en | input | 1 | Bit strobe; each strobe sends one bit |
| cfg_pre_m1 | input | 9 | Preamble length in bytes, minus one |
| cfg_sync_m1 | input | 2 | Sync length in bytes, minus one |
| cfg_sync_word | input | 32 | Sync pattern, first byte in bits 31:24 |
| cfg_hdr_len | input | 3 | Header byte count, 0 to 4 |
| cfg_hdr | input | 32 | Header bytes, first byte in bits 31:24 |
| cfg_pay_len | input | 8 | Payload byte count |
| cfg_crc_en | input | 1 | Appends the two CRC bytes |
| irq_en | input | 3 | Per-source interrupt enables |
| irq_rd | input | 1 | Status read strobe; clears the status |
| irq_status | output | 3 | Bit 0 sent, bit 1 underflow, bit 2 overflow |
| irq_n | output | 1 | Active-low interrupt |
| tx_bit | output | 1 | Serial output |
| tx_busy | output | 1 | A packet is in progress |

## Verification
The assertions check several rules on every cycle. The FIFO level never passes 64 and does not move on a write while full. A clear always leaves the FIFO empty. An event always lands in its status bit, and a read with no event leaves the status at zero. The framer leaves busy only on a bit strobe, never starts without a command, and flags underflow only while busy. The bench shows what needs a whole frame to judge. It compares the serial stream bit by bit against a model frame, with its own CRC, under random field lengths, contents and strobe spacing. Its directed cases cover the 512-byte preamble, a start pulse in the middle of a packet, an underflow, and the fill-level points where the threshold flags switch.

// File: rtl/txf_pkg.sv
// Shared types and the CRC step for the TX packet framer.
// Assumes byte-wise CRC-16 with polynomial 0x1021, data MSB first.
package txf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_SYNC,
        ST_HDR,
        ST_PAY,
        ST_CRCH,
        ST_CRCL
    } fr_state_t;

    localparam int unsigned IRQ_SENT  = 0;
    localparam int unsigned IRQ_UNDER = 1;
    localparam int unsigned IRQ_OVER  = 2;
    localparam int unsigned IRQ_N     = 3;

    // Advance the CRC register over one data byte, MSB first.
    function automatic logic [15:0] crc16_byte(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            if (r[15] ^ d[i]) r = {r[14:0], 1'b0} ^ 16'h1021;
            else              r = {r[14:0], 1'b0};
        end
        return r;
    endfunction

endpackage

// File: rtl/txf_fifo.sv
// Transmit byte FIFO with fill level and threshold flags.
// Assumes DEPTH is a power of two. Clear has priority over read and write.
// A write while full is dropped and reported on ovf.
module txf_fifo #(
    parameter int DEPTH  = 64,
    parameter int THR_W  = 6,
    parameter int AF_DEF = 55,
    parameter int AE_DEF = 4,
    localparam int AW    = $clog2(DEPTH),
    localparam int LW    = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic             rd_en,
    output logic [7:0]       rd_data,
    output logic             empty,
    output logic [LW-1:0]    level,
    output logic             afull,
    output logic             aempty,
    output logic             ovf,
    input  logic             thr_wr,
    input  logic [THR_W-1:0] thr_af_in,
    input  logic [THR_W-1:0] thr_ae_in
);

    logic [7:0]       mem [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic [LW-1:0]    lvl;
    logic [THR_W-1:0] thr_af, thr_ae;
    logic             full, push, pop;

    assign full  = (lvl == LW'(DEPTH));
    assign empty = (lvl == '0);
    assign push  = wr_en && !full && !clr;
    assign pop   = rd_en && !empty && !clr;
    assign ovf   = wr_en && full && !clr;

    // Store an accepted byte.
    always_ff @(posedge clk) begin
        if (push) mem[wp] <= wr_data;
    end

    // Pointer and fill-level update.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wp  <= '0;
            rp  <= '0;
            lvl <= '0;
        end else begin
            if (push) wp <= wp + AW'(1);
            if (pop)  rp <= rp + AW'(1);
            case ({push, pop})
                2'b10:   lvl <= lvl + LW'(1);
                2'b01:   lvl <= lvl - LW'(1);
                default: lvl <= lvl;
            endcase
        end
    end

    // Threshold registers with reset defaults.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_af <= THR_W'(AF_DEF);
            thr_ae <= THR_W'(AE_DEF);
        end else if (thr_wr) begin
            thr_af <= thr_af_in;
            thr_ae <= thr_ae_in;
        end
    end

    assign rd_data = mem[rp];
    assign level   = lvl;
    assign afull   = (lvl >  LW'(thr_af));
    assign aempty  = (lvl <= LW'(thr_ae));

    a_r7_level_max: assert property (@(posedge clk) disable iff (!rst_n)
        lvl <= LW'(DEPTH));
    a_r7_full_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_en && !clr) |=> (lvl == LW'(DEPTH)));
    a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (lvl == '0));

endmodule

// File: rtl/txf_irq.sv
// Latched event status with per-source enables and an active-low interrupt.
// A read strobe clears all bits, but an event in the same cycle wins.
module txf_irq #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] en,
    input  logic         rd,
    output logic [N-1:0] status,
    output logic         irq_n
);

    // Sticky status, cleared by read.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= set | (status & ~{N{rd}});
    end

    assign irq_n = ~|(status & en);

    for (genvar i = 0; i < N; i++) begin : g_chk
        a_r10_event_sticks: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> status[i]);
    end

    a_r11_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && (set == '0)) |=> (status == '0));

endmodule

// File: rtl/txf_framer.sv
// Frame sequencer and bit serializer. Assumes the configuration inputs are
// stable while busy. A new byte is chosen at the end of each byte; the CRC
// is updated when a header or payload byte is loaded. SYNC_MAX and HDR_MAX
// are at least 2.
module txf_framer
    import txf_pkg::*;
#(
    parameter int PRE_W    = 9,
    parameter int PAY_W    = 8,
    parameter int SYNC_MAX = 4,
    parameter int HDR_MAX  = 4,
    localparam int SI_W    = $clog2(SYNC_MAX),
    localparam int HI_W    = $clog2(HDR_MAX),
    localparam int HL_W    = $clog2(HDR_MAX + 1),
    localparam int CNT_W   = (PRE_W > PAY_W) ? PRE_W : PAY_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tx_start,
    input  logic                  bit_en,
    input  logic [PRE_W-1:0]      cfg_pre_m1,
    input  logic [SI_W-1:0]       cfg_sync_m1,
    input  logic [8*SYNC_MAX-1:0] cfg_sync_word,
    input  logic [HL_W-1:0]       cfg_hdr_len,
    input  logic [8*HDR_MAX-1:0]  cfg_hdr,
    input  logic [PAY_W-1:0]      cfg_pay_len,
    input  logic                  cfg_crc_en,
    input  logic [7:0]            fifo_rdata,
    input  logic                  fifo_empty,
    output logic                  fifo_pop,
    output logic                  tx_bit,
    output logic                  busy,
    output logic                  sent_pulse,
    output logic                  under_pulse
);

    fr_state_t            st, nxt_st, after_sync, after_hdr, after_pay;
    logic [CNT_W-1:0]     cnt, nxt_cnt;
    logic [7:0]           sh, nxt_byte;
    logic [2:0]           bitc;
    logic [15:0]          crc;
    logic                 byte_end, load_pay;
    logic [8*SYNC_MAX-1:0] sync_sh;
    logic [8*HDR_MAX-1:0]  hdr_sh;

    assign busy     = (st != ST_IDLE);
    assign byte_end = busy && bit_en && (bitc == 3'd7);

    // Which field follows a field that has just finished.
    always_comb begin
        after_pay  = cfg_crc_en ? ST_CRCH : ST_IDLE;
        after_hdr  = (cfg_pay_len != '0) ? ST_PAY : after_pay;
        after_sync = (cfg_hdr_len != '0) ? ST_HDR : after_hdr;
    end

    // Field and byte index of the next byte.
    always_comb begin
        nxt_st  = st;
        nxt_cnt = cnt + CNT_W'(1);
        unique case (st)
            ST_PRE:  if (cnt == CNT_W'(cfg_pre_m1)) begin
                         nxt_st = ST_SYNC; nxt_cnt = '0;
                     end
            ST_SYNC: if (cnt == CNT_W'(cfg_sync_m1)) begin
                         nxt_st = after_sync; nxt_cnt = '0;
                     end
            ST_HDR:  if (cnt == CNT_W'(cfg_hdr_len) - CNT_W'(1)) begin
                         nxt_st = after_hdr; nxt_cnt = '0;
                     end
            ST_PAY:  if (cnt == CNT_W'(cfg_pay_len) - CNT_W'(1)) begin
                         nxt_st = after_pay; nxt_cnt = '0;
                     end
            ST_CRCH: begin nxt_st = ST_CRCL; nxt_cnt = '0; end
            ST_CRCL: begin nxt_st = ST_IDLE; nxt_cnt = '0; end
            default: begin nxt_st = ST_IDLE; nxt_cnt = '0; end
        endcase
    end

    // Content of the next byte.
    always_comb begin
        sync_sh = cfg_sync_word << {nxt_cnt[SI_W-1:0], 3'b000};
        hdr_sh  = cfg_hdr << {nxt_cnt[HI_W-1:0], 3'b000};
        unique case (nxt_st)
            ST_PRE:  nxt_byte = 8'h55;
            ST_SYNC: nxt_byte = sync_sh[8*SYNC_MAX-1 -: 8];
            ST_HDR:  nxt_byte = hdr_sh[8*HDR_MAX-1 -: 8];
            ST_PAY:  nxt_byte = fifo_empty ? 8'h00 : fifo_rdata;
            ST_CRCH: nxt_byte = crc[15:8];
            ST_CRCL: nxt_byte = crc[7:0];
            default: nxt_byte = 8'h00;
        endcase
    end

    assign load_pay    = byte_end && (nxt_st == ST_PAY);
    assign fifo_pop    = load_pay && !fifo_empty;
    assign under_pulse = load_pay && fifo_empty;
    assign sent_pulse  = byte_end && (nxt_st == ST_IDLE);

    // Sequencer, shifter and CRC register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            sh     <= '0;
            bitc   <= '0;
            crc    <= 16'hFFFF;
            tx_bit <= 1'b0;
        end else if (st == ST_IDLE) begin
            if (tx_start) begin
                st   <= ST_PRE;
                cnt  <= '0;
                sh   <= 8'h55;
                bitc <= '0;
                crc  <= 16'hFFFF;
            end
        end else if (bit_en) begin
            tx_bit <= sh[7];
            bitc   <= bitc + 3'd1;
            if (bitc == 3'd7) begin
                st  <= nxt_st;
                cnt <= nxt_cnt;
                sh  <= nxt_byte;
                if (nxt_st == ST_HDR || nxt_st == ST_PAY)
                    crc <= crc16_byte(crc, nxt_byte);
            end else begin
                sh <= {sh[6:0], 1'b0};
            end
        end
    end

    a_r5_stop_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(bit_en));
    a_r5_no_self_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !tx_start) |=> !busy);
    a_r5_idle_output_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(tx_bit));
    a_r6_underflow_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        under_pulse |-> busy);

endmodule

// File: rtl/pkt_tx_framer.sv
// Top of the TX packet framer: FIFO, frame serializer and interrupt status.
// Status bit 0 sent, 1 underflow, 2 overflow.
module pkt_tx_framer
    import txf_pkg::*;
#(
    parameter int DEPTH    = 64,
    parameter int THR_W    = 6,
    parameter int PRE_W    = 9,
    parameter int PAY_W    = 8,
    parameter int SYNC_MAX = 4,
    parameter int HDR_MAX  = 4,
    localparam int LW      = $clog2(DEPTH) + 1,
    localparam int SI_W    = $clog2(SYNC_MAX),
    localparam int HL_W    = $clog2(HDR_MAX + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fifo_wr,
    input  logic [7:0]            fifo_wdata,
    input  logic                  fifo_clr,
    input  logic                  thr_wr,
    input  logic [THR_W-1:0]      thr_afull,
    input  logic [THR_W-1:0]      thr_aempty,
    output logic [LW-1:0]         fifo_level,
    output logic                  fifo_afull,
    output logic                  fifo_aempty,
    input  logic                  tx_start,
    input  logic                  bit_en,
    input  logic [PRE_W-1:0]      cfg_pre_m1,
    input  logic [SI_W-1:0]       cfg_sync_m1,
    input  logic [8*SYNC_MAX-1:0] cfg_sync_word,
    input  logic [HL_W-1:0]       cfg_hdr_len,
    input  logic [8*HDR_MAX-1:0]  cfg_hdr,
    input  logic [PAY_W-1:0]      cfg_pay_len,
    input  logic                  cfg_crc_en,
    input  logic [IRQ_N-1:0]      irq_en,
    input  logic                  irq_rd,
    output logic [IRQ_N-1:0]      irq_status,
    output logic                  irq_n,
    output logic                  tx_bit,
    output logic                  tx_busy
);

    logic [7:0]       rdata;
    logic             empty, pop, ovf, sent, under;
    logic [IRQ_N-1:0] ev;

    txf_fifo #(.DEPTH(DEPTH), .THR_W(THR_W), .AF_DEF(55), .AE_DEF(4)) u_fifo (
        .clk(clk), .rst_n(rst_n), .clr(fifo_clr),
        .wr_en(fifo_wr), .wr_data(fifo_wdata),
        .rd_en(pop), .rd_data(rdata), .empty(empty),
        .level(fifo_level), .afull(fifo_afull), .aempty(fifo_aempty), .ovf(ovf),
        .thr_wr(thr_wr), .thr_af_in(thr_afull), .thr_ae_in(thr_aempty)
    );

    txf_framer #(.PRE_W(PRE_W), .PAY_W(PAY_W), .SYNC_MAX(SYNC_MAX), .HDR_MAX(HDR_MAX)) u_framer (
        .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .bit_en(bit_en),
        .cfg_pre_m1(cfg_pre_m1), .cfg_sync_m1(cfg_sync_m1), .cfg_sync_word(cfg_sync_word),
        .cfg_hdr_len(cfg_hdr_len), .cfg_hdr(cfg_hdr), .cfg_pay_len(cfg_pay_len),
        .cfg_crc_en(cfg_crc_en), .fifo_rdata(rdata), .fifo_empty(empty),
        .fifo_pop(pop), .tx_bit(tx_bit), .busy(tx_busy),
        .sent_pulse(sent), .under_pulse(under)
    );

    always_comb begin
        ev            = '0;
        ev[IRQ_SENT]  = sent;
        ev[IRQ_UNDER] = under;
        ev[IRQ_OVER]  = ovf;
    end

    txf_irq #(.N(IRQ_N)) u_irq (
        .clk(clk), .rst_n(rst_n), .set(ev), .en(irq_en), .rd(irq_rd),
        .status(irq_status), .irq_n(irq_n)
    );

endmodule

// File: tb/pkt_tx_framer_tb.sv
module pkt_tx_framer_tb;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n, fifo_wr, fifo_clr, thr_wr, tx_start, bit_en, cfg_crc_en, irq_rd;
    logic [7:0]  fifo_wdata, cfg_pay_len;
    logic [5:0]  thr_afull, thr_aempty;
    logic [6:0]  fifo_level;
    logic        fifo_afull, fifo_aempty, irq_n, tx_bit, tx_busy;
    logic [8:0]  cfg_pre_m1;
    logic [1:0]  cfg_sync_m1;
    logic [31:0] cfg_sync_word, cfg_hdr;
    logic [2:0]  cfg_hdr_len, irq_en, irq_status;

    pkt_tx_framer u_dut (
        .clk(clk), .rst_n(rst_n), .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata),
        .fifo_clr(fifo_clr), .thr_wr(thr_wr), .thr_afull(thr_afull), .thr_aempty(thr_aempty),
        .fifo_level(fifo_level), .fifo_afull(fifo_afull), .fifo_aempty(fifo_aempty),
        .tx_start(tx_start), .bit_en(bit_en), .cfg_pre_m1(cfg_pre_m1),
        .cfg_sync_m1(cfg_sync_m1), .cfg_sync_word(cfg_sync_word), .cfg_hdr_len(cfg_hdr_len),
        .cfg_hdr(cfg_hdr), .cfg_pay_len(cfg_pay_len), .cfg_crc_en(cfg_crc_en),
        .irq_en(irq_en), .irq_rd(irq_rd), .irq_status(irq_status), .irq_n(irq_n),
        .tx_bit(tx_bit), .tx_busy(tx_busy)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [7:0] mq [64];
    int         mq_head = 0;
    int         mq_cnt  = 0;
    logic [7:0] exp_b [1024];
    int         exp_n;
    int         exp_under;

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_ref(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        logic        fb;
        r = c;
        for (int k = 0; k < 8; k++) begin
            fb = r[15] ^ d[7-k];
            r  = r << 1;
            if (fb) r = r ^ 16'h1021;
        end
        return r;
    endfunction

    task automatic pulse_clr();
        fifo_clr = 1'b1; @(negedge clk); fifo_clr = 1'b0;
        mq_head = 0; mq_cnt = 0;
    endtask

    task automatic push_byte(input logic [7:0] b);
        fifo_wr = 1'b1; fifo_wdata = b; @(negedge clk); fifo_wr = 1'b0;
        if (mq_cnt < 64) begin
            mq[(mq_head + mq_cnt) % 64] = b;
            mq_cnt++;
        end
    endtask

    task automatic read_status();
        irq_rd = 1'b1; @(negedge clk); irq_rd = 1'b0;
    endtask

    task automatic build_expected();
        logic [15:0] c;
        logic [7:0]  b;
        c = 16'hFFFF; exp_n = 0; exp_under = 0;
        for (int i = 0; i <= int'(cfg_pre_m1); i++) begin exp_b[exp_n] = 8'h55; exp_n++; end
        for (int i = 0; i <= int'(cfg_sync_m1); i++) begin
            exp_b[exp_n] = cfg_sync_word[31-8*i -: 8]; exp_n++;
        end
        for (int i = 0; i < int'(cfg_hdr_len); i++) begin
            b = cfg_hdr[31-8*i -: 8]; c = crc_ref(c, b); exp_b[exp_n] = b; exp_n++;
        end
        for (int i = 0; i < int'(cfg_pay_len); i++) begin
            if (mq_cnt > 0) begin
                b = mq[mq_head]; mq_head = (mq_head + 1) % 64; mq_cnt--;
            end else begin
                b = 8'h00; exp_under = 1;
            end
            c = crc_ref(c, b); exp_b[exp_n] = b; exp_n++;
        end
        if (cfg_crc_en) begin
            exp_b[exp_n] = c[15:8]; exp_n++;
            exp_b[exp_n] = c[7:0];  exp_n++;
        end
    endtask

    // Send one packet, compare every bit, then check and clear the status.
    task automatic run_packet(input string req, input bit poke_start);
        int         errs;
        int         first_bad;
        logic [7:0] eb;
        logic       exb;
        errs = 0; first_bad = -1;
        build_expected();
        tx_start = 1'b1; @(negedge clk); tx_start = 1'b0;
        chk("R5", "busy after start", int'(tx_busy), 1);
        for (int k = 0; k < exp_n * 8; k++) begin
            int gap;
            gap = int'($urandom_range(2, 0));
            repeat (gap) @(negedge clk);
            bit_en = 1'b1;
            if (poke_start && k == 13) tx_start = 1'b1;
            @(negedge clk);
            bit_en = 1'b0; tx_start = 1'b0;
            eb  = exp_b[k / 8];
            exb = eb[7 - (k % 8)];
            if (tx_bit !== exb) begin
                errs++;
                if (first_bad < 0) first_bad = k;
            end
            if (k < exp_n * 8 - 1 && !tx_busy) begin
                errs++;
                if (first_bad < 0) first_bad = k;
                break;
            end
        end
        chk(req, "serial stream mismatches", errs, 0);
        if (first_bad >= 0) $display("  first bad bit index %0d of %0d", first_bad, exp_n * 8);
        chk("R5", "busy after last bit", int'(tx_busy), 0);
        chk("R5", "sent status bit", int'(irq_status[0]), 1);
        chk("R6", "underflow status bit", int'(irq_status[1]), exp_under);
        chk("R10", "irq_n with sent enabled", int'(irq_n), 0);
        read_status();
        chk("R11", "status after read", int'(irq_status), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected run to complete");
        finish_run();
    end

    initial begin
        logic tx_prev;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; fifo_wr = 0; fifo_clr = 0; thr_wr = 0; tx_start = 0; bit_en = 0;
        irq_rd = 0; fifo_wdata = 0; thr_afull = 0; thr_aempty = 0;
        cfg_pre_m1 = 0; cfg_sync_m1 = 0; cfg_sync_word = 32'h2DD4_0000; cfg_hdr_len = 0;
        cfg_hdr = 0; cfg_pay_len = 0; cfg_crc_en = 0; irq_en = 3'b000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        chk("R12", "tx_busy", int'(tx_busy), 0);
        chk("R12", "tx_bit", int'(tx_bit), 0);
        chk("R12", "fifo_level", int'(fifo_level), 0);
        chk("R12", "irq_status", int'(irq_status), 0);
        chk("R12", "irq_n", int'(irq_n), 1);

        // R9 default thresholds 55 and 4
        for (int i = 0; i < 4; i++) push_byte(8'(i));
        chk("R9", "aempty at level 4", int'(fifo_aempty), 1);
        push_byte(8'h04);
        chk("R9", "aempty at level 5", int'(fifo_aempty), 0);
        for (int i = 5; i < 55; i++) push_byte(8'(i));
        chk("R9", "afull at level 55", int'(fifo_afull), 0);
        push_byte(8'h37);
        chk("R9", "afull at level 56", int'(fifo_afull), 1);
        for (int i = 56; i < 64; i++) push_byte(8'(i));
        chk("R7", "level when full", int'(fifo_level), 64);

        // R7 overflow, R10 disabled source
        push_byte(8'hEE);
        chk("R7", "level after write while full", int'(fifo_level), 64);
        chk("R7", "overflow status bit", int'(irq_status[2]), 1);
        chk("R10", "irq_n with overflow disabled", int'(irq_n), 1);
        irq_en = 3'b100; @(negedge clk);
        chk("R10", "irq_n with overflow enabled", int'(irq_n), 0);

        // R11 event in the read cycle survives
        fifo_wr = 1'b1; fifo_wdata = 8'hEF; irq_rd = 1'b1; @(negedge clk);
        fifo_wr = 1'b0; irq_rd = 1'b0;
        chk("R11", "overflow bit with same-cycle read", int'(irq_status[2]), 1);
        read_status();
        chk("R11", "status after plain read", int'(irq_status), 0);
        chk("R10", "irq_n after clear", int'(irq_n), 1);

        // R8 clear
        pulse_clr();
        chk("R8", "level after clear", int'(fifo_level), 0);
        chk("R8", "aempty after clear", int'(fifo_aempty), 1);

        // R9 loaded thresholds 10 and 0
        thr_afull = 6'd10; thr_aempty = 6'd0; thr_wr = 1'b1; @(negedge clk); thr_wr = 1'b0;
        push_byte(8'h11);
        chk("R9", "aempty at level 1, threshold 0", int'(fifo_aempty), 0);
        for (int i = 1; i < 10; i++) push_byte(8'(i));
        chk("R9", "afull at level 10, threshold 10", int'(fifo_afull), 0);
        push_byte(8'h22);
        chk("R9", "afull at level 11, threshold 10", int'(fifo_afull), 1);
        pulse_clr();
        thr_afull = 6'd55; thr_aempty = 6'd4; thr_wr = 1'b1; @(negedge clk); thr_wr = 1'b0;

        irq_en = 3'b011;

        // R3 short directed packet
        cfg_pre_m1 = 0; cfg_sync_m1 = 0; cfg_hdr_len = 0; cfg_pay_len = 3; cfg_crc_en = 0;
        push_byte(8'hA5); push_byte(8'h3C); push_byte(8'hF0);
        run_packet("R3", 1'b0);

        // R5 no restart without a command
        push_byte(8'h81); push_byte(8'h42); push_byte(8'h24);
        tx_prev = tx_bit;
        for (int i = 0; i < 20; i++) begin
            bit_en = 1'b1; @(negedge clk); bit_en = 1'b0; @(negedge clk);
        end
        chk("R5", "busy without start", int'(tx_busy), 0);
        chk("R5", "level kept without start", int'(fifo_level), 3);
        chk("R5", "tx_bit held while idle", int'(tx_bit), int'(tx_prev));

        // R4 CRC with header, and a start pulse while busy
        cfg_pre_m1 = 1; cfg_sync_m1 = 1; cfg_sync_word = 32'h2DD4_AA55;
        cfg_hdr_len = 2; cfg_hdr = 32'hC3A1_0000; cfg_pay_len = 3; cfg_crc_en = 1;
        run_packet("R4", 1'b1);

        // R1 longest preamble
        cfg_pre_m1 = 9'd511; cfg_sync_m1 = 2; cfg_hdr_len = 0; cfg_pay_len = 1; cfg_crc_en = 1;
        push_byte(8'h96);
        run_packet("R1", 1'b0);

        // R6 underflow: 4 owed, 2 present
        cfg_pre_m1 = 0; cfg_sync_m1 = 0; cfg_hdr_len = 1; cfg_hdr = 32'h5A00_0000;
        cfg_pay_len = 4; cfg_crc_en = 1;
        push_byte(8'h12); push_byte(8'h34);
        run_packet("R6", 1'b0);

        // R2 four-byte sync, four header bytes, no payload
        cfg_pre_m1 = 2; cfg_sync_m1 = 3; cfg_sync_word = 32'h1ACF_FC1D;
        cfg_hdr_len = 4; cfg_hdr = 32'hDEAD_BEEF; cfg_pay_len = 0; cfg_crc_en = 1;
        run_packet("R2", 1'b0);

        // R3 random packets
        for (int p = 0; p < 10; p++) begin
            cfg_pre_m1    = 9'($urandom_range(3, 0));
            cfg_sync_m1   = 2'($urandom_range(3, 0));
            cfg_sync_word = $urandom;
            cfg_hdr_len   = 3'($urandom_range(4, 0));
            cfg_hdr       = $urandom;
            cfg_pay_len   = 8'($urandom_range(20, 0));
            cfg_crc_en    = 1'($urandom_range(1, 0));
            for (int i = 0; i < int'(cfg_pay_len); i++) push_byte(8'($urandom));
            run_packet("R3", 1'b0);
        end

        finish_run();
    end

endmodule